// File: doc/BRIEF.md
# USB Control Endpoint Setup and Automatic Address Unit

This unit handles endpoint zero of a USB device controller at the transaction level. It takes already decoded packets: a token strobe with its kind, device address and endpoint number, a byte stream with valid and last strobes for the data that follows a token, and the host's handshake after the device has sent data. It stores the eight bytes of every setup packet in byte registers that firmware reads by index. It then either reports the request to firmware or, if the request is a well-formed SetAddress, handles it alone.

For requests that firmware handles, the unit holds the following stage until firmware releases it. It sets a force-NAK bit and a protect bit when the setup arrives. Firmware then writes the stage direction and clears both bits. For a SetAddress, the unit answers the IN status stage with a zero-length packet. It moves the device onto the new address only after the host acknowledges that packet, and at the same moment raises a completion flag.

Top module: `usbEp0Unit`

## Requirements
- R1: After reset the device address is 0, both status flags are 0, and the direction, force-NAK and protect bits are 0.
- R2: A SETUP token (tokType 2) whose address equals the current device address and whose endpoint is 0 gets an ACK reply (replyCode 3) one cycle later. The eight following data bytes are stored so that byte i (i = 0 being the first byte on the wire) reads back on setupRdByte when setupRdSel = i. Tokens to another address or another endpoint get no reply and leave the stored bytes unchanged.
- R3: When a captured request is not a valid SetAddress, setupFlag rises, and forceNak and protect are both 1 by that time.
- R4: An IN (tokType 1) or OUT (tokType 0) token to endpoint 0 at the current address, outside an automatic status stage, gets a reply one cycle later. The reply is NAK (replyCode 0) while forceNak or protect is 1 and PASS (replyCode 2) once firmware has cleared both through a control write.
- R5: A control write (ctrlWr) loads the direction bit from ctrlDir, where 0 selects an OUT data stage and 1 selects IN. Entering an automatic SetAddress status stage sets the direction bit to 1.
- R6: A request is a valid SetAddress only when byte 0 is 0x00, byte 1 is 0x05, byte 2 is at most 0x7F, and bytes 3 to 7 are all 0x00. A valid SetAddress does not raise setupFlag. Any other content is reported as in R3.
- R7: In the automatic status stage, an IN token to endpoint 0 gets a zero-length reply (replyCode 1). A following handshake with hsAck = 1 sets devAddr to byte 2 of the request and raises addrDoneFlag. A handshake with hsAck = 0 leaves the address unchanged and keeps the unit in the status stage.
- R8: Until the new address takes effect, the unit answers only on the old address, and tokens to the new address get no reply.
- R9: A new SETUP on endpoint 0 cancels any stage in progress, including a pending automatic SetAddress, and the stored bytes are replaced.
- R10: setupFlag and addrDoneFlag stay at 1 until a one-cycle pulse on clrSetupFlag or clrAddrFlag, respectively, clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tokValid | input | 1 | Token strobe |
| tokType | input | 2 | Token kind: 0 OUT, 1 IN, 2 SETUP, 3 other |
| tokAddr | input | 7 | Token device address |
| tokEp | input | 4 | Token endpoint number |
| dataValid | input | 1 | Data byte strobe |
| dataByte | input | 8 | Data byte |
| dataLast | input | 1 | Last byte of the data packet |
| hsValid | input | 1 | Host handshake strobe after device-sent data |
| hsAck | input | 1 | 1 = host ACK, 0 = timeout |
| ctrlWr | input | 1 | Firmware write of the three control bits |
| ctrlDir | input | 1 | Direction value to write |
| ctrlNak | input | 1 | Force-NAK value to write |
| ctrlProt | input | 1 | Protect value to write |
| clrSetupFlag | input | 1 | Write-one-to-clear for setupFlag |
| clrAddrFlag | input | 1 | Write-one-to-clear for addrDoneFlag |
| setupRdSel | input | 3 | Setup byte index to read |
| replyValid | output | 1 | Reply strobe, one cycle after a matching token |
| replyCode | output | 2 | 0 NAK, 1 zero-length data, 2 pass to data path, 3 ACK |
| setupRdByte | output | 8 | Selected setup byte |
| devAddr | output | 7 | Current device address |
| setupFlag | output | 1 | Sticky setup-received flag |
| addrDoneFlag | output | 1 | Sticky SetAddress-complete flag |
| ep0Dir | output | 1 | Stage direction, 1 = IN |
| forceNak | output | 1 | Force-NAK bit |
| protect | output | 1 | Protect bit |

## Verification
A wrong stage state shows up as a wrong reply code on the very next IN or OUT token. A stuck automatic stage answers zero-length where NAK or PASS is expected, and a stage that never reaches the status step never answers zero-length at all. A faulty validity decode shows up two cycles after the last setup byte, either as a setupFlag that should not rise or as a missing flag. An address applied at the wrong time shows up one cycle after the handshake, either as a devAddr change or as a token ignored on the address the bench expects.

// File: rtl/usbEp0Pkg.sv
package usbEp0Pkg;
  localparam int ADDR_W      = 7;
  localparam int EP_W        = 4;
  localparam int SETUP_BYTES = 8;
  localparam int IDX_W       = $clog2(SETUP_BYTES);

  typedef enum logic [1:0] {
    TOK_OUT   = 2'd0,
    TOK_IN    = 2'd1,
    TOK_SETUP = 2'd2,
    TOK_OTHER = 2'd3
  } tokKind_e;

  typedef enum logic [1:0] {
    RSP_NAK  = 2'd0,
    RSP_ZLP  = 2'd1,
    RSP_PASS = 2'd2,
    RSP_ACK  = 2'd3
  } rspKind_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic             armSetup;
    logic             capWr;
    logic [IDX_W-1:0] capIdx;
    logic             raiseSetup;
    logic             enterAuto;
    logic             applyAddr;
    logic             rspValid;
    rspKind_e         rspCode;
  } ep0Strobe_t;
endpackage

// File: rtl/ep0Control.sv
module ep0Control
  import usbEp0Pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tokValid,
  input  logic [1:0]        tokType,
  input  logic [ADDR_W-1:0] tokAddr,
  input  logic [EP_W-1:0]   tokEp,
  input  logic              dataValid,
  input  logic              dataLast,
  input  logic              hsValid,
  input  logic              hsAck,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic              stageHeld,
  input  logic              isSetAddr,
  output ep0Strobe_t        strobe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SETUP_BYTES - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CAP, ST_EVAL, ST_AUTO, ST_HSWAIT
  } ep0State_e;

  ep0State_e state, stateNxt;
  logic [IDX_W-1:0] idx, idxNxt;
  logic hit;
  tokKind_e kind;

  assign kind = tokKind_e'(tokType);
  assign hit  = tokValid && (tokAddr == curAddr) && (tokEp == '0);

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    idxNxt   = idx;
    if (hit && kind == TOK_SETUP) begin
      strobe.armSetup = 1'b1;
      strobe.rspValid = 1'b1;
      strobe.rspCode  = RSP_ACK;
      stateNxt        = ST_CAP;
      idxNxt          = '0;
    end else begin
      if (hit && (kind == TOK_IN || kind == TOK_OUT)) begin
        strobe.rspValid = 1'b1;
        strobe.rspCode  = stageHeld ? RSP_NAK : RSP_PASS;
      end
      case (state)
        ST_CAP: begin
          if (dataValid) begin
            strobe.capWr  = 1'b1;
            strobe.capIdx = idx;
            idxNxt        = idx + 1'b1;
            if (dataLast)
              stateNxt = (idx == LAST_IDX) ? ST_EVAL : ST_IDLE;
            else if (idx == LAST_IDX)
              stateNxt = ST_IDLE;
          end
        end
        ST_EVAL: begin
          if (isSetAddr) begin
            strobe.enterAuto = 1'b1;
            stateNxt         = ST_AUTO;
          end else begin
            strobe.raiseSetup = 1'b1;
            stateNxt          = ST_IDLE;
          end
        end
        ST_AUTO, ST_HSWAIT: begin
          if (hit && kind == TOK_IN) begin
            strobe.rspCode = RSP_ZLP;
            stateNxt       = ST_HSWAIT;
          end else if (hit && kind == TOK_OUT) begin
            strobe.rspCode = RSP_NAK;
          end else if (state == ST_HSWAIT && hsValid) begin
            if (hsAck) begin
              strobe.applyAddr = 1'b1;
              stateNxt         = ST_IDLE;
            end else begin
              stateNxt = ST_AUTO;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      state <= stateNxt;
      idx   <= idxNxt;
    end
  end
endmodule

// File: rtl/ep0Datapath.sv
module ep0Datapath
  import usbEp0Pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ep0Strobe_t        strobe,
  input  logic [7:0]        dataByte,
  input  logic              ctrlWr,
  input  logic              ctrlDir,
  input  logic              ctrlNak,
  input  logic              ctrlProt,
  input  logic              clrSetupFlag,
  input  logic              clrAddrFlag,
  input  logic [IDX_W-1:0]  setupRdSel,
  output logic [7:0]        setupRdByte,
  output logic [ADDR_W-1:0] devAddr,
  output logic              setupFlag,
  output logic              addrDoneFlag,
  output logic              ep0Dir,
  output logic              forceNak,
  output logic              protect,
  output logic              stageHeld,
  output logic              isSetAddr,
  output logic              replyValid,
  output logic [1:0]        replyCode
);
  logic [7:0] setupMem [SETUP_BYTES];
  logic [ADDR_W-1:0] pendAddr;

  for (genvar i = 0; i < SETUP_BYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rstN)
        setupMem[i] <= '0;
      else if (strobe.capWr && strobe.capIdx == IDX_W'(i))
        setupMem[i] <= dataByte;
    end
  end

  assign setupRdByte = setupMem[setupRdSel];

  always_comb begin
    isSetAddr = (setupMem[0] == 8'h00) && (setupMem[1] == 8'h05) && !setupMem[2][7];
    for (int i = 3; i < SETUP_BYTES; i++)
      if (setupMem[i] != 8'h00) isSetAddr = 1'b0;
  end

  assign stageHeld = forceNak | protect;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendAddr     <= '0;
      devAddr      <= '0;
      setupFlag    <= 1'b0;
      addrDoneFlag <= 1'b0;
      ep0Dir       <= 1'b0;
      forceNak     <= 1'b0;
      protect      <= 1'b0;
      replyValid   <= 1'b0;
      replyCode    <= '0;
    end else begin
      replyValid <= strobe.rspValid;
      replyCode  <= strobe.rspCode;
      if (strobe.enterAuto) pendAddr <= setupMem[2][ADDR_W-1:0];
      if (strobe.applyAddr) devAddr <= pendAddr;

      if (strobe.raiseSetup)  setupFlag <= 1'b1;
      else if (clrSetupFlag)  setupFlag <= 1'b0;
      if (strobe.applyAddr)   addrDoneFlag <= 1'b1;
      else if (clrAddrFlag)   addrDoneFlag <= 1'b0;

      if (strobe.enterAuto)   ep0Dir <= 1'b1;
      else if (ctrlWr)        ep0Dir <= ctrlDir;

      if (strobe.armSetup || strobe.raiseSetup) begin
        forceNak <= 1'b1;
        protect  <= 1'b1;
      end else if (ctrlWr) begin
        forceNak <= ctrlNak;
        protect  <= ctrlProt;
      end
    end
  end
endmodule

// File: rtl/usbEp0Unit.sv
module usbEp0Unit
  import usbEp0Pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tokValid,
  input  logic [1:0]        tokType,
  input  logic [ADDR_W-1:0] tokAddr,
  input  logic [EP_W-1:0]   tokEp,
  input  logic              dataValid,
  input  logic [7:0]        dataByte,
  input  logic              dataLast,
  input  logic              hsValid,
  input  logic              hsAck,
  input  logic              ctrlWr,
  input  logic              ctrlDir,
  input  logic              ctrlNak,
  input  logic              ctrlProt,
  input  logic              clrSetupFlag,
  input  logic              clrAddrFlag,
  input  logic [IDX_W-1:0]  setupRdSel,
  output logic              replyValid,
  output logic [1:0]        replyCode,
  output logic [7:0]        setupRdByte,
  output logic [ADDR_W-1:0] devAddr,
  output logic              setupFlag,
  output logic              addrDoneFlag,
  output logic              ep0Dir,
  output logic              forceNak,
  output logic              protect
);
  ep0Strobe_t strobe;
  logic stageHeld;
  logic isSetAddr;

  ep0Control u_ctrl (
    .clk, .rstN, .tokValid, .tokType, .tokAddr, .tokEp,
    .dataValid, .dataLast, .hsValid, .hsAck,
    .curAddr(devAddr), .stageHeld, .isSetAddr, .strobe
  );

  ep0Datapath u_dp (
    .clk, .rstN, .strobe, .dataByte, .ctrlWr, .ctrlDir, .ctrlNak, .ctrlProt,
    .clrSetupFlag, .clrAddrFlag, .setupRdSel, .setupRdByte, .devAddr,
    .setupFlag, .addrDoneFlag, .ep0Dir, .forceNak, .protect,
    .stageHeld, .isSetAddr, .replyValid, .replyCode
  );
endmodule

// File: rtl/usbEp0Checker.sv
module usbEp0Checker
  import usbEp0Pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              tokValid,
  input logic [1:0]        tokType,
  input logic              hsValid,
  input logic              hsAck,
  input logic              clrSetupFlag,
  input logic              clrAddrFlag,
  input logic              replyValid,
  input logic [1:0]        replyCode,
  input logic [ADDR_W-1:0] devAddr,
  input logic              setupFlag,
  input logic              addrDoneFlag,
  input logic              forceNak,
  input logic              protect
);
  // R4
  reply_after_token_chk: assert property (@(posedge clk) disable iff (!rstN)
    replyValid |-> $past(tokValid));

  // R7
  zlp_only_for_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    (replyValid && replyCode == 2'd1) |-> $past(tokValid && tokType == 2'd1));

  // R7
  addr_moves_on_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(devAddr) |-> ($past(hsValid && hsAck) && addrDoneFlag));

  // R3
  setup_flag_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(setupFlag) |-> (forceNak && protect));

  // R10
  setup_flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(setupFlag) |-> $past(clrSetupFlag));

  // R10
  addr_flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(addrDoneFlag) |-> $past(clrAddrFlag));
endmodule

bind usbEp0Unit usbEp0Checker u_chk (
  .clk, .rstN, .tokValid, .tokType, .hsValid, .hsAck,
  .clrSetupFlag, .clrAddrFlag, .replyValid, .replyCode, .devAddr,
  .setupFlag, .addrDoneFlag, .forceNak, .protect
);

// File: tb/usbEp0Unit_bench.sv
`timescale 1ns/100ps
module usbEp0Unit_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tokValid = 0; logic [1:0] tokType = 0; logic [6:0] tokAddr = 0; logic [3:0] tokEp = 0;
  logic dataValid = 0; logic [7:0] dataByte = 0; logic dataLast = 0;
  logic hsValid = 0, hsAck = 0;
  logic ctrlWr = 0, ctrlDir = 0, ctrlNak = 0, ctrlProt = 0;
  logic clrSetupFlag = 0, clrAddrFlag = 0;
  logic [2:0] setupRdSel = 0;
  logic replyValid; logic [1:0] replyCode; logic [7:0] setupRdByte; logic [6:0] devAddr;
  logic setupFlag, addrDoneFlag, ep0Dir, forceNak, protect;

  int total = 0, bad = 0;
  logic [6:0] curAddr = 0;
  logic rVal; logic [1:0] rCode;
  logic [63:0] rb;

  always #2.5 clk = ~clk;

  usbEp0Unit u_usbEp0Unit (.*);

  // {expect automatic handling, bytes 7..0}
  localparam logic [64:0] VEC [7] = '{
    {1'b1, 64'h0000_0000_0012_0500},
    {1'b0, 64'h0012_0000_0100_0680},
    {1'b0, 64'h0000_0000_0080_0500},
    {1'b0, 64'h0001_0000_0005_0500},
    {1'b0, 64'h0000_0000_0033_0580},
    {1'b1, 64'h0000_0000_007F_0500},
    {1'b0, 64'h0000_0001_0010_0500}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic sendTok(input logic [1:0] t, input logic [6:0] a, input logic [3:0] e);
    tokValid = 1; tokType = t; tokAddr = a; tokEp = e;
    @(negedge clk);
    tokValid = 0;
    rVal = replyValid; rCode = replyCode;
  endtask

  task automatic sendSetup(input logic [6:0] a, input logic [3:0] e, input logic [63:0] p);
    sendTok(2'd2, a, e);
    for (int i = 0; i < 8; i++) begin
      dataValid = 1; dataByte = p[8*i +: 8]; dataLast = (i == 7);
      @(negedge clk);
    end
    dataValid = 0; dataLast = 0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic readPkt(output logic [63:0] p);
    for (int i = 0; i < 8; i++) begin
      setupRdSel = 3'(i); #0.2;
      p[8*i +: 8] = setupRdByte;
    end
    @(negedge clk);
  endtask

  task automatic sendHs(input logic ack);
    hsValid = 1; hsAck = ack;
    @(negedge clk);
    hsValid = 0;
  endtask

  task automatic ctrl(input logic d, input logic n, input logic pr);
    ctrlWr = 1; ctrlDir = d; ctrlNak = n; ctrlProt = pr;
    @(negedge clk);
    ctrlWr = 0;
  endtask

  task automatic pulseClr(input bit which);
    if (which) clrAddrFlag = 1; else clrSetupFlag = 1;
    @(negedge clk);
    clrAddrFlag = 0; clrSetupFlag = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk({devAddr, setupFlag, addrDoneFlag, ep0Dir, forceNak, protect} == '0, "R1",
        {devAddr, setupFlag, addrDoneFlag, ep0Dir, forceNak, protect}, 0);

    foreach (VEC[v]) begin
      sendSetup(curAddr, 4'd0, VEC[v][63:0]);
      chk(rVal && rCode == 2'd3, "R2 setup ack", {rVal, rCode}, 3'b111);
      readPkt(rb);
      chk(rb == VEC[v][63:0], "R2 bytes", rb, VEC[v][63:0]);
      chk(forceNak && protect, "R3 held", {forceNak, protect}, 2'b11);
      if (VEC[v][64]) begin
        chk(setupFlag == 0, "R6 no flag", setupFlag, 0);
        chk(ep0Dir == 1, "R5 auto dir", ep0Dir, 1);
        sendTok(2'd1, curAddr, 4'd0);
        chk(rVal && rCode == 2'd1, "R7 zlp", {rVal, rCode}, 3'b101);
        sendHs(1'b1);
        curAddr = VEC[v][22:16];
        chk(devAddr == curAddr && addrDoneFlag, "R7 apply", {addrDoneFlag, devAddr}, {1'b1, curAddr});
        pulseClr(1'b1);
        chk(addrDoneFlag == 0, "R10 addr clr", addrDoneFlag, 0);
      end else begin
        chk(setupFlag == 1, "R6 reported", setupFlag, 1);
        repeat (3) @(negedge clk);
        chk(setupFlag == 1, "R10 sticky", setupFlag, 1);
        pulseClr(1'b0);
        chk(setupFlag == 0, "R10 setup clr", setupFlag, 0);
      end
    end

    // R2 ignore wrong address and endpoint
    sendSetup(curAddr + 7'd1, 4'd0, 64'hDEAD_BEEF_0000_1111);
    chk(rVal == 0, "R2 wrong addr", rVal, 0);
    sendSetup(curAddr, 4'd1, 64'hDEAD_BEEF_0000_2222);
    chk(rVal == 0, "R2 wrong ep", rVal, 0);
    readPkt(rb);
    chk(rb == VEC[6][63:0], "R2 bytes kept", rb, VEC[6][63:0]);
    chk(setupFlag == 0, "R2 no flag", setupFlag, 0);

    // R4 / R5 stage release
    sendSetup(curAddr, 4'd0, 64'h0040_0000_0200_0680);
    pulseClr(1'b0);
    sendTok(2'd1, curAddr, 4'd0);
    chk(rVal && rCode == 2'd0, "R4 nak held", {rVal, rCode}, 3'b100);
    ctrl(1'b1, 1'b1, 1'b0);
    chk(ep0Dir == 1, "R5 dir in", ep0Dir, 1);
    sendTok(2'd1, curAddr, 4'd0);
    chk(rVal && rCode == 2'd0, "R4 nak only", {rVal, rCode}, 3'b100);
    ctrl(1'b0, 1'b0, 1'b0);
    chk(ep0Dir == 0, "R5 dir out", ep0Dir, 0);
    sendTok(2'd0, curAddr, 4'd0);
    chk(rVal && rCode == 2'd2, "R4 pass", {rVal, rCode}, 3'b110);

    // R7 / R8 timeout then retry
    sendSetup(curAddr, 4'd0, 64'h0000_0000_0033_0500);
    sendTok(2'd1, curAddr, 4'd0);
    chk(rVal && rCode == 2'd1, "R7 zlp first", {rVal, rCode}, 3'b101);
    sendHs(1'b0);
    chk(devAddr == curAddr && !addrDoneFlag, "R7 timeout", devAddr, curAddr);
    sendTok(2'd1, 7'h33, 4'd0);
    chk(rVal == 0, "R8 new addr idle", rVal, 0);
    sendTok(2'd1, curAddr, 4'd0);
    chk(rVal && rCode == 2'd1, "R8 old addr zlp", {rVal, rCode}, 3'b101);
    sendHs(1'b1);
    curAddr = 7'h33;
    chk(devAddr == 7'h33 && addrDoneFlag, "R7 retry apply", devAddr, 7'h33);
    pulseClr(1'b1);

    // R9 override of pending automatic stage
    sendSetup(curAddr, 4'd0, 64'h0000_0000_0044_0500);
    sendSetup(curAddr, 4'd0, 64'h0012_0000_0100_0680);
    chk(setupFlag == 1, "R9 flag", setupFlag, 1);
    readPkt(rb);
    chk(rb == 64'h0012_0000_0100_0680, "R9 recapture", rb, 64'h0012_0000_0100_0680);
    sendTok(2'd1, curAddr, 4'd0);
    chk(rVal && rCode == 2'd0, "R9 nak not zlp", {rVal, rCode}, 3'b100);
    sendHs(1'b1);
    @(negedge clk);
    chk(devAddr == curAddr && !addrDoneFlag, "R9 no apply", devAddr, curAddr);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule